// File: doc/BRIEF.md
# SPI Serial Clock Divider with Power-of-Two and Linear Schemes

This block derives the serial clock of an SPI master from the module clock. It does not drive a clock net. It emits single-cycle pulses on the module clock, one for each leading edge and one for each trailing edge of the serial clock, together with a level signal that follows the serial clock waveform. A shift register beside it uses those pulses to launch and capture bits.

A 13-bit configuration word picks the division ratio. Bit 12 selects the scheme. When bit 12 is 0 the ratio is a power of two: the 4-bit exponent N in bits 11:8 gives a serial clock period of 2^(N+1) module clocks. When bit 12 is 1 the ratio is linear: the 8-bit count N in bits 7:0 gives a period of 2*(N+1) module clocks. In both schemes the smallest ratio is 2, reached with N = 0.

The block captures the configuration word only while `run` is low. While `run` is low the divider also holds its counter at zero. When `run` rises, the first edge therefore comes one full half-period later. Choosing a divisor for a target frequency is left to software.

Top module: `spi_sclk_divider`

## Requirements
- R1: While `run` is low, `lead_tick`, `trail_tick` and `sclk_lvl` are all 0 from the next cycle on, whatever `div_cfg` holds. After reset all three are 0.
- R2: With `div_cfg[12]` = 0 and N = `div_cfg[11:8]`, the half-period is 2^N module clocks, so the serial clock period is 2^(N+1).
- R3: With `div_cfg[12]` = 1 and N = `div_cfg[7:0]`, the half-period is N+1 module clocks, so the serial clock period is 2*(N+1).
- R4: With N = 0 in either scheme, the ratio is 2: an edge pulse appears on every cycle while running, alternating between leading and trailing.
- R5: Counting the clock edge that first samples `run` high as edge 1, the first `lead_tick` is visible after edge H, where H is the half-period. After that the pulses fall every H edges.
- R6: Each pulse lasts one cycle. The pulses alternate leading, trailing, leading, and so on. `lead_tick` and `trail_tick` are never high together.
- R7: Changes to `div_cfg` while `run` is high do not change the running ratio. The block captures the new value once `run` has been low for a cycle.
- R8: `sclk_lvl` rises in the cycle that `lead_tick` is high, stays high until the next `trail_tick`, and falls in that cycle.
- R9: Dropping `run` in the middle of a half-period clears the pulses and the level on the next cycle. A later start again waits a full half-period before its first edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Transfer active; low holds the divider idle |
| div_cfg | input | 13 | Bit 12 scheme select, bits 11:8 exponent, bits 7:0 linear count |
| lead_tick | output | 1 | One-cycle pulse at each serial clock leading edge |
| trail_tick | output | 1 | One-cycle pulse at each serial clock trailing edge |
| sclk_lvl | output | 1 | Serial clock level, high between leading and trailing edge |

## Verification
The power-of-two scheme is swept over exponents 0 to 10, plus exponent 15 for the first edge only. The linear scheme is swept over every count from 0 to 63, plus 127, 200 and 255. Each run is checked edge by edge against a period computed arithmetically, which separates the two schemes and detects off-by-one half-periods and a wrong first-edge delay. Further patterns rewrite the configuration in mid-run and check that the running ratio stays the same until the next idle. Other patterns drop `run` partway through a half-period and check that a restart waits a full half-period again.

// File: rtl/spi_div_pkg.sv
package spi_div_pkg;

    // Default field widths of the configuration word
    localparam int unsigned DEF_EXP_W = 4;
    localparam int unsigned DEF_LIN_W = 8;

    typedef enum logic {
        DIV_POW2 = 1'b0,
        DIV_LIN  = 1'b1
    } div_mode_e;

    // Edge events produced for the shifter
    typedef struct packed {
        logic lead;
        logic trail;
        logic lvl;
    } sclk_evt_t;

    // Counter width able to hold the largest half-period minus one
    function automatic int unsigned cnt_width(input int unsigned exp_w,
                                              input int unsigned lin_w);
        int unsigned pw;
        pw = (1 << exp_w) - 1;
        return (pw > lin_w) ? pw : lin_w;
    endfunction

endpackage

// File: rtl/spi_div_cfg.sv
module spi_div_cfg
    import spi_div_pkg::*;
#(
    parameter int unsigned EXP_W = DEF_EXP_W,
    parameter int unsigned LIN_W = DEF_LIN_W,
    parameter int unsigned CNT_W = cnt_width(EXP_W, LIN_W)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     run,
    input  logic [EXP_W+LIN_W:0]     div_cfg,
    output logic [CNT_W-1:0]         half_m1
);
    localparam int unsigned SEL_BIT = EXP_W + LIN_W;

    div_mode_e          mode_f;
    logic [EXP_W-1:0]   exp_f;
    logic [LIN_W-1:0]   lin_f;
    logic [CNT_W-1:0]   pow_m1;
    logic [CNT_W-1:0]   half_m1_d;

    assign mode_f = div_mode_e'(div_cfg[SEL_BIT]);
    assign exp_f  = div_cfg[SEL_BIT-1:LIN_W];
    assign lin_f  = div_cfg[LIN_W-1:0];

    // 2^N - 1 as a mask of N low ones
    always_comb begin
        for (int i = 0; i < int'(CNT_W); i++) begin
            pow_m1[i] = (i < int'(exp_f));
        end
    end

    always_comb begin
        unique case (mode_f)
            DIV_POW2: half_m1_d = pow_m1;
            DIV_LIN:  half_m1_d = CNT_W'(lin_f);
            default:  half_m1_d = '0;
        endcase
    end

    // Capture only while idle
    always_ff @(posedge clk) begin
        if (rst) begin
            half_m1 <= '0;
        end else if (!run) begin
            half_m1 <= half_m1_d;
        end
    end

endmodule

// File: rtl/spi_div_count.sv
module spi_div_count #(
    parameter int unsigned CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [CNT_W-1:0] half_m1,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    assign wrap = run && (cnt == half_m1);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (wrap) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/spi_div_edge.sv
module spi_div_edge
    import spi_div_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      run,
    input  logic      wrap,
    output sclk_evt_t evt
);
    always_ff @(posedge clk) begin
        if (rst || !run) begin
            evt <= '0;
        end else begin
            evt.lead  <= wrap && !evt.lvl;
            evt.trail <= wrap &&  evt.lvl;
            if (wrap) begin
                evt.lvl <= !evt.lvl;
            end
        end
    end

endmodule

// File: rtl/spi_sclk_divider.sv
module spi_sclk_divider
    import spi_div_pkg::*;
#(
    parameter int unsigned EXP_W = DEF_EXP_W,
    parameter int unsigned LIN_W = DEF_LIN_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 run,
    input  logic [EXP_W+LIN_W:0] div_cfg,
    output logic                 lead_tick,
    output logic                 trail_tick,
    output logic                 sclk_lvl
);
    localparam int unsigned CNT_W = cnt_width(EXP_W, LIN_W);

    logic [CNT_W-1:0] half_m1;
    logic [CNT_W-1:0] cnt;
    logic             wrap;
    sclk_evt_t        evt;

    spi_div_cfg #(
        .EXP_W (EXP_W),
        .LIN_W (LIN_W),
        .CNT_W (CNT_W)
    ) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .div_cfg (div_cfg),
        .half_m1 (half_m1)
    );

    spi_div_count #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .half_m1 (half_m1),
        .cnt     (cnt),
        .wrap    (wrap)
    );

    spi_div_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .wrap (wrap),
        .evt  (evt)
    );

    assign lead_tick  = evt.lead;
    assign trail_tick = evt.trail;
    assign sclk_lvl   = evt.lvl;

endmodule

// File: rtl/spi_div_chk.sv
module spi_div_chk #(
    parameter int unsigned CNT_W = 15
) (
    input logic             clk,
    input logic             rst,
    input logic             run,
    input logic             lead_tick,
    input logic             trail_tick,
    input logic             sclk_lvl,
    input logic [CNT_W-1:0] half_m1,
    input logic [CNT_W-1:0] cnt
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> (!lead_tick && !trail_tick && !sclk_lvl));

    // R6
    edge_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(lead_tick && trail_tick));

    // R6
    lead_single_chk: assert property (@(posedge clk) disable iff (rst)
        lead_tick |=> !lead_tick);

    // R6
    trail_single_chk: assert property (@(posedge clk) disable iff (rst)
        trail_tick |=> !trail_tick);

    // R8
    lead_level_chk: assert property (@(posedge clk) disable iff (rst)
        lead_tick |-> sclk_lvl);

    // R8
    trail_level_chk: assert property (@(posedge clk) disable iff (rst)
        trail_tick |-> !sclk_lvl);

    // R7
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        run |=> (!run || $stable(half_m1)));

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt <= half_m1));

endmodule

bind spi_sclk_divider spi_div_chk #(
    .CNT_W (CNT_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .run        (run),
    .lead_tick  (lead_tick),
    .trail_tick (trail_tick),
    .sclk_lvl   (sclk_lvl),
    .half_m1    (half_m1),
    .cnt        (cnt)
);

// File: tb/tb_spi_sclk_divider.sv
module tb_spi_sclk_divider;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run = 1'b0;
    logic [12:0] div_cfg = '0;
    logic        lead_tick;
    logic        trail_tick;
    logic        sclk_lvl;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    spi_sclk_divider dut (
        .clk        (clk),
        .rst        (rst),
        .run        (run),
        .div_cfg    (div_cfg),
        .lead_tick  (lead_tick),
        .trail_tick (trail_tick),
        .sclk_lvl   (sclk_lvl)
    );

    function automatic logic [12:0] mk_cfg(input bit lin, input int n);
        if (lin) return {1'b1, 4'd0, 8'(n)};
        return {1'b0, 4'(n), 8'd0};
    endfunction

    function automatic int half_of(input bit lin, input int n);
        if (lin) return n + 1;
        return 1 << n;
    endfunction

    // Runs for nh half-periods and compares every cycle with the arithmetic waveform.
    // When alt_on is set, the configuration is rewritten one cycle after start.
    task automatic measure(input bit lin, input int n, input int nh,
                           input bit alt_on, input logic [12:0] alt, input string tag);
        int  h;
        bit  bad;
        int  bad_k;
        logic [2:0] act, exp_v, bad_act, bad_exp;
        h   = half_of(lin, n);
        bad = 1'b0;
        bad_k = 0; bad_act = '0; bad_exp = '0;
        @(negedge clk);
        run = 1'b0;
        div_cfg = mk_cfg(lin, n);
        @(negedge clk);
        @(negedge clk);
        run = 1'b1;
        for (int k = 1; k <= nh * h; k++) begin
            @(negedge clk);
            if (alt_on && k == 1) div_cfg = alt;
            exp_v[2] = (k % h == 0) && (((k / h) % 2) == 1);
            exp_v[1] = (k % h == 0) && (((k / h) % 2) == 0);
            exp_v[0] = ((k / h) % 2) == 1;
            act = {lead_tick, trail_tick, sclk_lvl};
            if (act !== exp_v && !bad) begin
                bad = 1'b1; bad_k = k; bad_act = act; bad_exp = exp_v;
            end
        end
        run = 1'b0;
        checks++;
        if (bad) begin
            errors++;
            $display("FAIL %s lin=%0d n=%0d cycle %0d actual lead/trail/lvl=%b expected %b",
                     tag, lin, n, bad_k, bad_act, bad_exp);
        end
    endtask

    task automatic expect_quiet(input string tag);
        checks++;
        if ({lead_tick, trail_tick, sclk_lvl} !== 3'b000) begin
            errors++;
            $display("FAIL %s actual lead/trail/lvl=%b expected 000", tag,
                     {lead_tick, trail_tick, sclk_lvl});
        end
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog actual %0d cycles expected completion", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        expect_quiet("R1 reset");
        rst = 1'b0;

        // R1: idle with several configurations
        for (int i = 0; i < 4; i++) begin
            div_cfg = (i % 2 == 1) ? mk_cfg(1'b1, i) : mk_cfg(1'b0, i);
            repeat (5) @(negedge clk);
            expect_quiet("R1 idle");
        end

        // R4: minimum ratio in both schemes
        measure(1'b0, 0, 8, 1'b0, '0, "R4 pow2 n=0");
        measure(1'b1, 0, 8, 1'b0, '0, "R4 lin n=0");

        // R2, R5, R6, R8: power-of-two sweep
        for (int n = 1; n <= 10; n++) measure(1'b0, n, 4, 1'b0, '0, "R2 R5 R6 R8 pow2");
        // R5: largest exponent, first leading edge only
        measure(1'b0, 15, 1, 1'b0, '0, "R5 pow2 n=15");

        // R3: linear sweep
        for (int n = 1; n <= 63; n++) measure(1'b1, n, 4, 1'b0, '0, "R3 lin");
        measure(1'b1, 127, 4, 1'b0, '0, "R3 lin");
        measure(1'b1, 200, 4, 1'b0, '0, "R3 lin");
        measure(1'b1, 255, 4, 1'b0, '0, "R3 lin");

        // R7: mid-run rewrite ignored, applied after idle
        measure(1'b1, 5, 6, 1'b1, mk_cfg(1'b0, 1), "R7 lin ignore");
        measure(1'b0, 1, 6, 1'b0, '0, "R7 pow2 applied");
        measure(1'b0, 3, 4, 1'b1, mk_cfg(1'b1, 0), "R7 pow2 ignore");

        // R9: drop mid half-period, then restart
        @(negedge clk);
        div_cfg = mk_cfg(1'b1, 9);
        @(negedge clk);
        @(negedge clk);
        run = 1'b1;
        repeat (16) @(negedge clk);
        run = 1'b0;
        @(negedge clk);
        expect_quiet("R9 drop");
        measure(1'b1, 9, 4, 1'b0, '0, "R9 restart");

        // R1: idle after activity
        repeat (4) @(negedge clk);
        expect_quiet("R1 after run");

        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule